// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data synchronously between a 12-bit narrow port and a 24-bit wide port. The wide port is made of a low half and a high half. Going from narrow to wide, two narrow words that arrive on successive clock edges are packed into one wide word. The low half sits behind a two-stage pipeline and the high half behind a single register, so the first word reaches the low half on the same edge that the second word reaches the high half.

Going from wide to narrow, each half is captured into its own register. A select input then returns one of the two halves to the narrow port, and the select acts without a clock edge. Every register has its own active-low load enable. The drive enables of both ports are sampled on the clock, so a change of bus direction only takes effect at the next rising edge.

Each bidirectional port appears as three vectors: an input, an output and an output enable. The surrounding logic resolves the tri-state bus. An active-low asynchronous reset clears every data register and turns off every output enable.

Top module: `bus_xchg`

## Requirements
- R1: A storage element changes only on a rising clock edge at which its own active-low load enable is low. At any other edge it keeps its value, and so does the output it feeds.
- R2: `w_lo_o` equals the `n_i` value sampled two edges earlier when `ld_nlo_ni` was low at both of those edges. The path is two register stages, both enabled by `ld_nlo_ni`.
- R3: `w_hi_o` equals the `n_i` value sampled one edge earlier when `ld_nhi_ni` was low at that edge. The path is a single register.
- R4: `w_lo_i` is captured into a low-half return register when `ld_wlo_ni` is low at an edge, and `w_hi_i` is captured into a high-half return register when `ld_whi_ni` is low at an edge.
- R5: With `sel_lo_i` = 1, `n_o` shows the low-half return register; with `sel_lo_i` = 0, it shows the high-half return register. A change of `sel_lo_i` reaches `n_o` in the same cycle, with no clock edge in between.
- R6: `n_oe_o` is all ones after an edge at which `n_drive_ni` was 0, and all zeros after an edge at which it was 1. `w_lo_oe_o` and `w_hi_oe_o` follow `w_drive_ni` in the same way. The two ports are independent and may be enabled together.
- R7: Packing. At edge 1, `ld_nlo_ni` is 0 and `ld_nhi_ni` is 1 with word0 on `n_i`. At edge 2, both enables are 0 with word1 on `n_i`. After edge 2, `w_lo_o` = word0 and `w_hi_o` = word1.
- R8: While `rst_ni` is 0, all data outputs read zero and all output-enable vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_i | input | 12 | Narrow port data as read from the bus |
| ld_nlo_ni | input | 1 | Load enable for the narrow-to-low pipeline, active low |
| ld_nhi_ni | input | 1 | Load enable for the narrow-to-high register, active low |
| ld_wlo_ni | input | 1 | Load enable for the low-half return register, active low |
| ld_whi_ni | input | 1 | Load enable for the high-half return register, active low |
| sel_lo_i | input | 1 | 1 returns the low half to the narrow port, 0 returns the high half |
| n_drive_ni | input | 1 | Narrow port drive request, active low, registered |
| w_drive_ni | input | 1 | Wide port drive request, active low, registered |
| w_lo_i | input | 12 | Wide port low half as read from the bus |
| w_hi_i | input | 12 | Wide port high half as read from the bus |
| n_o | output | 12 | Narrow port drive data |
| n_oe_o | output | 12 | Narrow port output enable per bit |
| w_lo_o | output | 12 | Wide port low half drive data |
| w_lo_oe_o | output | 12 | Wide low half output enable per bit |
| w_hi_o | output | 12 | Wide port high half drive data |
| w_hi_oe_o | output | 12 | Wide high half output enable per bit |

## Verification
The bench aims at the uneven pipeline depth. A design with one stage toward the low half would show word1 instead of word0 after a packing pair. A design with two stages toward the high half would show stale data there.

It also holds each load enable high while its input changes. A register that ignored its enable would overwrite held data.

It changes the select with no clock edge in between. A select that had been registered would lag by one cycle.

It changes the drive requests and checks the enables before the next edge. An output enable wired straight through would switch the bus in mid-cycle.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int unsigned XCHG_W = 12;
  localparam int unsigned XCHG_LO_DEPTH = 2;

  typedef enum logic {
    RET_HI = 1'b0,
    RET_LO = 1'b1
  } ret_sel_e;
endpackage

// File: rtl/xchg_en_reg.sv
module xchg_en_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!en_ni) q_o <= d_i;
  end
endmodule

// File: rtl/xchg_n2w_path.sv
module xchg_n2w_path #(
  parameter int unsigned W        = 12,
  parameter int unsigned LO_DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] n_i,
  input  logic         ld_lo_ni,
  input  logic         ld_hi_ni,
  output logic [W-1:0] lo_q_o,
  output logic [W-1:0] hi_q_o
);
  localparam int unsigned NODES = LO_DEPTH + 1;

  logic [W-1:0] chain [NODES];
  assign chain[0] = n_i;

  // low half: LO_DEPTH stages sharing one enable
  for (genvar g = 0; g < LO_DEPTH; g++) begin : g_lo_stage
    xchg_en_reg #(.W(W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_ni (ld_lo_ni),
      .d_i   (chain[g]),
      .q_o   (chain[g+1])
    );
  end

  assign lo_q_o = chain[LO_DEPTH];

  xchg_en_reg #(.W(W)) u_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (ld_hi_ni),
    .d_i   (n_i),
    .q_o   (hi_q_o)
  );
endmodule

// File: rtl/xchg_w2n_path.sv
module xchg_w2n_path
  import xchg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         ld_lo_ni,
  input  logic         ld_hi_ni,
  input  logic         sel_lo_i,
  output logic [W-1:0] n_o
);
  logic [W-1:0] lo_q, hi_q;
  ret_sel_e     sel;

  xchg_en_reg #(.W(W)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(ld_lo_ni), .d_i(lo_i), .q_o(lo_q)
  );
  xchg_en_reg #(.W(W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(ld_hi_ni), .d_i(hi_i), .q_o(hi_q)
  );

  assign sel = ret_sel_e'(sel_lo_i);

  // unregistered select
  always_comb begin
    unique case (sel)
      RET_LO:  n_o = lo_q;
      default: n_o = hi_q;
    endcase
  end
endmodule

// File: rtl/xchg_dir_ctl.sv
module xchg_dir_ctl #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         n_drive_ni,
  input  logic         w_drive_ni,
  output logic [W-1:0] n_oe_o,
  output logic [W-1:0] w_oe_o
);
  logic n_oe_q, w_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_oe_q <= 1'b0;
      w_oe_q <= 1'b0;
    end else begin
      n_oe_q <= ~n_drive_ni;
      w_oe_q <= ~w_drive_ni;
    end
  end

  assign n_oe_o = {W{n_oe_q}};
  assign w_oe_o = {W{w_oe_q}};
endmodule

// File: rtl/bus_xchg.sv
module bus_xchg
  import xchg_pkg::*;
#(
  parameter int unsigned W        = XCHG_W,
  parameter int unsigned LO_DEPTH = XCHG_LO_DEPTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] n_i,
  input  logic         ld_nlo_ni,
  input  logic         ld_nhi_ni,
  input  logic         ld_wlo_ni,
  input  logic         ld_whi_ni,
  input  logic         sel_lo_i,
  input  logic         n_drive_ni,
  input  logic         w_drive_ni,
  input  logic [W-1:0] w_lo_i,
  input  logic [W-1:0] w_hi_i,
  output logic [W-1:0] n_o,
  output logic [W-1:0] n_oe_o,
  output logic [W-1:0] w_lo_o,
  output logic [W-1:0] w_lo_oe_o,
  output logic [W-1:0] w_hi_o,
  output logic [W-1:0] w_hi_oe_o
);
  logic [W-1:0] w_oe;

  xchg_n2w_path #(.W(W), .LO_DEPTH(LO_DEPTH)) u_n2w (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .n_i     (n_i),
    .ld_lo_ni(ld_nlo_ni),
    .ld_hi_ni(ld_nhi_ni),
    .lo_q_o  (w_lo_o),
    .hi_q_o  (w_hi_o)
  );

  xchg_w2n_path #(.W(W)) u_w2n (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_i    (w_lo_i),
    .hi_i    (w_hi_i),
    .ld_lo_ni(ld_wlo_ni),
    .ld_hi_ni(ld_whi_ni),
    .sel_lo_i(sel_lo_i),
    .n_o     (n_o)
  );

  xchg_dir_ctl #(.W(W)) u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .n_drive_ni(n_drive_ni),
    .w_drive_ni(w_drive_ni),
    .n_oe_o    (n_oe_o),
    .w_oe_o    (w_oe)
  );

  assign w_lo_oe_o = w_oe;
  assign w_hi_oe_o = w_oe;
endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] n_i,
  input logic         ld_nlo_ni,
  input logic         ld_nhi_ni,
  input logic         ld_wlo_ni,
  input logic         ld_whi_ni,
  input logic         sel_lo_i,
  input logic         n_drive_ni,
  input logic         w_drive_ni,
  input logic [W-1:0] w_lo_i,
  input logic [W-1:0] w_hi_i,
  input logic [W-1:0] n_o,
  input logic [W-1:0] n_oe_o,
  input logic [W-1:0] w_lo_o,
  input logic [W-1:0] w_lo_oe_o,
  input logic [W-1:0] w_hi_o,
  input logic [W-1:0] w_hi_oe_o
);
  // edges since reset release, saturating
  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc <= '0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  p_lo_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && $past(ld_nlo_ni)) |-> $stable(w_lo_o));
  p_hi_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && $past(ld_nhi_ni)) |-> $stable(w_hi_o));
  p_lo_two_edges_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && !$past(ld_nlo_ni) && !$past(ld_nlo_ni, 2)) |-> w_lo_o == $past(n_i, 2));
  p_hi_one_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && !$past(ld_nhi_ni)) |-> w_hi_o == $past(n_i));
  p_ret_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && !$past(ld_wlo_ni) && sel_lo_i) |-> n_o == $past(w_lo_i));
  p_ret_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && !$past(ld_whi_ni) && !sel_lo_i) |-> n_o == $past(w_hi_i));
  p_n_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1) |-> n_oe_o == {W{!$past(n_drive_ni)}});
  p_w_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1) |-> (w_lo_oe_o == {W{!$past(w_drive_ni)}} && w_hi_oe_o == w_lo_oe_o));
  p_pack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && !$past(ld_nlo_ni) && !$past(ld_nhi_ni) && !$past(ld_nlo_ni, 2))
      |-> (w_lo_o == $past(n_i, 2) && w_hi_o == $past(n_i)));
endmodule

bind bus_xchg xchg_checker #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .n_i       (n_i),
  .ld_nlo_ni (ld_nlo_ni),
  .ld_nhi_ni (ld_nhi_ni),
  .ld_wlo_ni (ld_wlo_ni),
  .ld_whi_ni (ld_whi_ni),
  .sel_lo_i  (sel_lo_i),
  .n_drive_ni(n_drive_ni),
  .w_drive_ni(w_drive_ni),
  .w_lo_i    (w_lo_i),
  .w_hi_i    (w_hi_i),
  .n_o       (n_o),
  .n_oe_o    (n_oe_o),
  .w_lo_o    (w_lo_o),
  .w_lo_oe_o (w_lo_oe_o),
  .w_hi_o    (w_hi_o),
  .w_hi_oe_o (w_hi_oe_o)
);

// File: tb/bus_xchg_tb_top.sv
module bus_xchg_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 12;
  localparam int unsigned N_RAND = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] n_i = '0, w_lo_i = '0, w_hi_i = '0;
  logic ld_nlo_n = 1'b1, ld_nhi_n = 1'b1, ld_wlo_n = 1'b1, ld_whi_n = 1'b1;
  logic sel_lo = 1'b1, n_drive_n = 1'b1, w_drive_n = 1'b1;
  logic [W-1:0] n_o, n_oe, w_lo_o, w_lo_oe, w_hi_o, w_hi_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xchg #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .n_i(n_i),
    .ld_nlo_ni(ld_nlo_n), .ld_nhi_ni(ld_nhi_n),
    .ld_wlo_ni(ld_wlo_n), .ld_whi_ni(ld_whi_n),
    .sel_lo_i(sel_lo), .n_drive_ni(n_drive_n), .w_drive_ni(w_drive_n),
    .w_lo_i(w_lo_i), .w_hi_i(w_hi_i),
    .n_o(n_o), .n_oe_o(n_oe), .w_lo_o(w_lo_o), .w_lo_oe_o(w_lo_oe),
    .w_hi_o(w_hi_o), .w_hi_oe_o(w_hi_oe)
  );

  // reference state, built from the requirements
  logic [W-1:0] m_s1, m_lo, m_hi, m_rlo, m_rhi;
  logic m_noe, m_woe;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_lo <= '0; m_hi <= '0; m_rlo <= '0; m_rhi <= '0;
      m_noe <= 1'b0; m_woe <= 1'b0;
    end else begin
      if (!ld_nlo_n) begin m_s1 <= n_i; m_lo <= m_s1; end
      if (!ld_nhi_n) m_hi <= n_i;
      if (!ld_wlo_n) m_rlo <= w_lo_i;
      if (!ld_whi_n) m_rhi <= w_hi_i;
      m_noe <= !n_drive_n;
      m_woe <= !w_drive_n;
    end
  end

  function automatic logic [W-1:0] exp_ret(logic s, logic [W-1:0] lo, logic [W-1:0] hi);
    return s ? lo : hi;
  endfunction

  function automatic logic [W-1:0] exp_oe(logic on);
    return on ? {W{1'b1}} : {W{1'b0}};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 w_lo_o", w_lo_o, '0);
    chk("R8 w_hi_o", w_hi_o, '0);
    chk("R8 n_o", n_o, '0);
    chk("R8 n_oe_o", n_oe, '0);
    chk("R8 w_lo_oe_o", w_lo_oe, '0);
    chk("R8 w_hi_oe_o", w_hi_oe, '0);
    rst_n = 1'b1;

    // R7 packing pair
    @(negedge clk);
    n_i = 12'hA5A; ld_nlo_n = 1'b0; ld_nhi_n = 1'b1;
    @(negedge clk);
    chk("R2 lo not yet after one edge", w_lo_o, '0);
    n_i = 12'h3C3; ld_nlo_n = 1'b0; ld_nhi_n = 1'b0;
    @(negedge clk);
    ld_nlo_n = 1'b1; ld_nhi_n = 1'b1;
    chk("R7 w_lo_o word0", w_lo_o, 12'hA5A);
    chk("R7 w_hi_o word1", w_hi_o, 12'h3C3);

    // R1 hold with enables high
    n_i = 12'hFFF;
    @(negedge clk);
    @(negedge clk);
    chk("R1 w_lo_o held", w_lo_o, 12'hA5A);
    chk("R1 w_hi_o held", w_hi_o, 12'h3C3);

    // R4 / R5 return path
    w_lo_i = 12'h111; w_hi_i = 12'h222; ld_wlo_n = 1'b0; ld_whi_n = 1'b0; sel_lo = 1'b1;
    @(negedge clk);
    ld_wlo_n = 1'b1; ld_whi_n = 1'b1;
    chk("R4 n_o low half", n_o, 12'h111);
    sel_lo = 1'b0;
    #1;
    chk("R5 n_o high half without edge", n_o, 12'h222);
    w_lo_i = 12'h999; w_hi_i = 12'h888;
    @(negedge clk);
    chk("R1 return register held", n_o, 12'h222);

    // R6 registered drive enables
    n_drive_n = 1'b0;
    #1;
    chk("R6 n_oe_o waits for edge", n_oe, '0);
    @(negedge clk);
    chk("R6 n_oe_o on", n_oe, {W{1'b1}});
    chk("R6 w_lo_oe_o off", w_lo_oe, '0);
    w_drive_n = 1'b0;
    @(negedge clk);
    chk("R6 both on n", n_oe, {W{1'b1}});
    chk("R6 both on w_hi", w_hi_oe, {W{1'b1}});
    n_drive_n = 1'b1;
    @(negedge clk);
    chk("R6 n off", n_oe, '0);
    chk("R6 w_lo stays on", w_lo_oe, {W{1'b1}});

    // constrained random against the reference state
    for (int i = 0; i < N_RAND; i++) begin
      @(negedge clk);
      chk("R2 w_lo_o", w_lo_o, m_lo);
      chk("R3 w_hi_o", w_hi_o, m_hi);
      chk("R5 n_o", n_o, exp_ret(sel_lo, m_rlo, m_rhi));
      chk("R6 n_oe_o", n_oe, exp_oe(m_noe));
      chk("R6 w_hi_oe_o", w_hi_oe, exp_oe(m_woe));
      n_i      = W'($urandom);
      w_lo_i   = W'($urandom);
      w_hi_i   = W'($urandom);
      ld_nlo_n = ($urandom % 3) == 0;
      ld_nhi_n = ($urandom % 3) == 0;
      ld_wlo_n = ($urandom % 2) == 0;
      ld_whi_n = ($urandom % 2) == 0;
      sel_lo   = 1'($urandom);
      n_drive_n = ($urandom % 4) == 0;
      w_drive_n = ($urandom % 4) == 0;
    end
    @(negedge clk);
    chk("R2 w_lo_o final", w_lo_o, m_lo);
    chk("R3 w_hi_o final", w_hi_o, m_hi);
    finish_run();
  end
endmodule